// File: doc/BRIEF.md
# Interrupt Gate Descriptor Checker

This block validates a gate entry taken from an interrupt descriptor table for one vector. It receives the vector number, the table limit, the current privilege level, a flag for software-initiated interrupts, a flag for 64-bit long mode, and the raw gate bytes. For long mode the gate is 16 bytes and arrives as two 64-bit words. It also receives a few decoded fields of the code-segment descriptor that the gate points at. The block does not fetch that descriptor; the fields arrive already decoded.

The block applies its checks in a fixed order and reports the first one that fails. A failure gives a fault kind, either general protection or not present, and a 16-bit fault code. If every check passes, the block reports the decoded gate type, target selector, entry offset and stack-table index. It also reports two flags: whether the handler runs at a more privileged level, and whether the interrupt-enable flag is to be cleared. A request is one cycle with `req_valid` high. The result is registered and shows up on the next cycle, marked by `rsp_valid`.

Gate layout in the low 64-bit word:
- bits 15:0: offset bits 15:0
- bits 31:16: target selector
- bits 36:32: parameter field
- bits 43:40: type
- bit 44: segment flag
- bits 46:45: gate privilege level
- bit 47: present
- bits 63:48: offset bits 31:16

In long mode the high word carries offset bits 63:32 in bits 31:0, and its bits 44:40 are reserved and must be zero.

Top module: `idt_gate_checker`

## Requirements
- R1: Results are registered. `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and the other outputs keep their values while no request arrives. After reset all outputs are zero. Fault kind encodings are 0 for none, 1 for general protection and 2 for not present. With kind 0 the fault code is 0.
- R2: The table limit check fails when vector*8+7 exceeds the limit, or when vector*16+15 exceeds it in long mode. The result is general protection with code vector*8+2.
- R3: In long mode, a high gate word with any of bits 44:40 set gives general protection with code vector*8+2.
- R4: Legal types are 5, 6, 7, 14 and 15 outside long mode, and only 14 and 15 in long mode. Any other type, or a set segment flag, gives general protection with code vector*8+2.
- R5: For a software interrupt, a gate privilege level numerically below the current level gives general protection with code vector*8+2. For other requests the gate privilege level has no effect.
- R6: A clear present bit gives not-present with code vector*8+2.
- R7: For interrupt and trap gates, a target selector whose bits 15:2 are all zero gives general protection with code 0.
- R8: A target that is not a code segment, or whose privilege level exceeds the current level, gives general protection with code equal to the selector with bits 1:0 cleared. A target that is not present gives not-present with the same code.
- R9: Checks are applied in this priority order, and only the first failure is reported: limit, reserved bits, type, software privilege, present, null selector, target kind and privilege, target present.
- R10: The offset is the 32-bit legacy offset, extended with the high word's bits 31:0 as bits 63:32 in long mode and with zeros otherwise. The stack-table index is bits 34:32 of the low word in long mode and 0 otherwise.
- R11: On success with an interrupt or trap gate, `clear_if` is set for even types and clear for odd types. `inner_priv` is set when the target is non-conforming and its privilege level is below the current level. Both flags are zero on any fault.
- R12: A task gate (type 5) that passes the present check is reported as success, with kind 0, `inner_priv` 0 and `clear_if` 0. The selector check and the target checks do not apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Check request, one cycle |
| vector | input | VEC_W | Interrupt vector number |
| tbl_limit | input | LIM_W | Descriptor table limit in bytes |
| sw_int | input | 1 | Request comes from a software interrupt |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 16-byte gates and the long-mode rules apply |
| gate_lo | input | 64 | Low 8 bytes of the gate |
| gate_hi | input | 64 | High 8 bytes of the gate (long mode only) |
| tgt_is_code | input | 1 | Target descriptor is a code segment |
| tgt_dpl | input | 2 | Target descriptor privilege level |
| tgt_present | input | 1 | Target descriptor present bit |
| tgt_conforming | input | 1 | Target code segment is conforming |
| rsp_valid | output | 1 | Result valid this cycle |
| fault_kind | output | 2 | 0 none, 1 general protection, 2 not present |
| fault_code | output | 16 | Error code for the fault |
| gate_type | output | 4 | Gate type field |
| tgt_sel | output | 16 | Target selector from the gate |
| tgt_offset | output | 64 | Handler entry offset |
| stack_idx | output | 3 | Stack-table index |
| inner_priv | output | 1 | Handler runs at a more privileged level |
| clear_if | output | 1 | Interrupt-enable flag to be cleared |

## Verification
Each result appears one clock edge after the request edge, since it passes through one register stage only. The bench drives a request on a falling edge, holds it across one rising edge, and samples every output on the next falling edge, when `rsp_valid` must be high. Another sample one cycle later, with no request, shows that `rsp_valid` has dropped and that the outputs have held their values. The reset state is sampled before any request is made.

// File: rtl/igc_pkg.sv
package igc_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 64;
    localparam int CODE_W = 16;
    localparam int TYPE_W = 4;
    localparam int IST_W  = 3;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_GP   = 2'd1,
        FK_NP   = 2'd2
    } fault_e;

    // decoded gate fields
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [OFF_W-1:0]  off;
        logic [TYPE_W-1:0] gtype;
        logic              seg;
        logic [1:0]        dpl;
        logic              present;
        logic [IST_W-1:0]  ist;
        logic              rsvd_nz;
    } gate_t;

    // registered result
    typedef struct packed {
        logic              vld;
        fault_e            kind;
        logic [CODE_W-1:0] code;
        logic [TYPE_W-1:0] gtype;
        logic [SEL_W-1:0]  sel;
        logic [OFF_W-1:0]  off;
        logic [IST_W-1:0]  ist;
        logic              inner;
        logic              clr_if;
    } result_t;

endpackage

// File: rtl/igc_field_split.sv
module igc_field_split
    import igc_pkg::*;
(
    input  logic [63:0] gate_lo,
    input  logic [63:0] gate_hi,
    input  logic        long_mode,
    output gate_t       fields
);
    localparam int RSVD_LO = 40;
    localparam int RSVD_HI = 44;

    always_comb begin
        fields.sel     = gate_lo[31:16];
        fields.gtype   = gate_lo[43:40];
        fields.seg     = gate_lo[44];
        fields.dpl     = gate_lo[46:45];
        fields.present = gate_lo[47];
        if (long_mode) begin
            fields.off     = {gate_hi[31:0], gate_lo[63:48], gate_lo[15:0]};
            fields.ist     = gate_lo[34:32];
            fields.rsvd_nz = |gate_hi[RSVD_HI:RSVD_LO];
        end else begin
            fields.off     = {32'h0, gate_lo[63:48], gate_lo[15:0]};
            fields.ist     = '0;
            fields.rsvd_nz = 1'b0;
        end
    end
endmodule

// File: rtl/igc_limit_cmp.sv
module igc_limit_cmp #(
    parameter int VEC_W = 8,
    parameter int LIM_W = 16
) (
    input  logic [VEC_W-1:0] vector,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             long_mode,
    output logic             over
);
    localparam int END_W = VEC_W + 4;
    localparam int CMP_W = ((LIM_W > END_W) ? LIM_W : END_W) + 1;

    logic [CMP_W-1:0] end_addr;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        // last byte of the entry: 16-byte entries in long mode, 8-byte otherwise
        if (long_mode) end_addr = CMP_W'({vector, 4'hF});
        else           end_addr = CMP_W'({vector, 3'h7});
        lim_ext = CMP_W'(tbl_limit);
        over    = end_addr > lim_ext;
    end
endmodule

// File: rtl/igc_rule_chain.sv
module igc_rule_chain
    import igc_pkg::*;
#(
    parameter int          VEC_W       = 8,
    parameter logic [15:0] LEGACY_MASK = 16'hC0E0,
    parameter logic [15:0] LONG_MASK   = 16'hC000,
    parameter logic [3:0]  TASK_TYPE   = 4'd5
) (
    input  logic [VEC_W-1:0]  vector,
    input  logic              over,
    input  logic              long_mode,
    input  logic              sw_int,
    input  logic [1:0]        cpl,
    input  gate_t             fields,
    input  logic              tgt_is_code,
    input  logic [1:0]        tgt_dpl,
    input  logic              tgt_present,
    input  logic              tgt_conforming,
    output fault_e            kind,
    output logic [CODE_W-1:0] code,
    output logic              inner,
    output logic              clr_if
);
    logic [CODE_W-1:0] vec_code;
    logic [CODE_W-1:0] sel_code;
    logic [15:0]       mask;
    logic              type_ok;
    logic              is_task;

    always_comb begin
        vec_code = CODE_W'({vector, 3'b010});
        sel_code = {fields.sel[SEL_W-1:2], 2'b00};
        mask     = long_mode ? LONG_MASK : LEGACY_MASK;
        type_ok  = !fields.seg && mask[fields.gtype];
        is_task  = fields.gtype == TASK_TYPE;

        kind   = FK_NONE;
        code   = '0;
        inner  = 1'b0;
        clr_if = 1'b0;

        // first failing check wins
        if (over) begin
            kind = FK_GP; code = vec_code;
        end else if (fields.rsvd_nz) begin
            kind = FK_GP; code = vec_code;
        end else if (!type_ok) begin
            kind = FK_GP; code = vec_code;
        end else if (sw_int && (fields.dpl < cpl)) begin
            kind = FK_GP; code = vec_code;
        end else if (!fields.present) begin
            kind = FK_NP; code = vec_code;
        end else if (is_task) begin
            kind = FK_NONE;
        end else if (fields.sel[SEL_W-1:2] == '0) begin
            kind = FK_GP; code = '0;
        end else if (!tgt_is_code || (tgt_dpl > cpl)) begin
            kind = FK_GP; code = sel_code;
        end else if (!tgt_present) begin
            kind = FK_NP; code = sel_code;
        end else begin
            inner  = !tgt_conforming && (tgt_dpl < cpl);
            clr_if = !fields.gtype[0];
        end
    end
endmodule

// File: rtl/idt_gate_checker.sv
module idt_gate_checker
    import igc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] vector,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             sw_int,
    input  logic [1:0]       cpl,
    input  logic             long_mode,
    input  logic [63:0]      gate_lo,
    input  logic [63:0]      gate_hi,
    input  logic             tgt_is_code,
    input  logic [1:0]       tgt_dpl,
    input  logic             tgt_present,
    input  logic             tgt_conforming,
    output logic             rsp_valid,
    output logic [1:0]       fault_kind,
    output logic [15:0]      fault_code,
    output logic [3:0]       gate_type,
    output logic [15:0]      tgt_sel,
    output logic [63:0]      tgt_offset,
    output logic [2:0]       stack_idx,
    output logic             inner_priv,
    output logic             clear_if
);
    gate_t             fields;
    logic              over;
    fault_e            kind_c;
    logic [CODE_W-1:0] code_c;
    logic              inner_c;
    logic              clr_c;
    result_t           res_d;
    result_t           res_q;

    igc_field_split u_split (
        .gate_lo   (gate_lo),
        .gate_hi   (gate_hi),
        .long_mode (long_mode),
        .fields    (fields)
    );

    igc_limit_cmp #(.VEC_W(VEC_W), .LIM_W(LIM_W)) u_limit (
        .vector    (vector),
        .tbl_limit (tbl_limit),
        .long_mode (long_mode),
        .over      (over)
    );

    igc_rule_chain #(.VEC_W(VEC_W)) u_rules (
        .vector         (vector),
        .over           (over),
        .long_mode      (long_mode),
        .sw_int         (sw_int),
        .cpl            (cpl),
        .fields         (fields),
        .tgt_is_code    (tgt_is_code),
        .tgt_dpl        (tgt_dpl),
        .tgt_present    (tgt_present),
        .tgt_conforming (tgt_conforming),
        .kind           (kind_c),
        .code           (code_c),
        .inner          (inner_c),
        .clr_if         (clr_c)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        if (req_valid) begin
            res_d.kind   = kind_c;
            res_d.code   = code_c;
            res_d.gtype  = fields.gtype;
            res_d.sel    = fields.sel;
            res_d.off    = fields.off;
            res_d.ist    = fields.ist;
            res_d.inner  = inner_c;
            res_d.clr_if = clr_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rsp_valid  = res_q.vld;
    assign fault_kind = res_q.kind;
    assign fault_code = res_q.code;
    assign gate_type  = res_q.gtype;
    assign tgt_sel    = res_q.sel;
    assign tgt_offset = res_q.off;
    assign stack_idx  = res_q.ist;
    assign inner_priv = res_q.inner;
    assign clear_if   = res_q.clr_if;
endmodule

// File: rtl/igc_checker.sv
module igc_checker #(
    parameter int VEC_W = 8,
    parameter int LIM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VEC_W-1:0] vector,
    input logic [LIM_W-1:0] tbl_limit,
    input logic             long_mode,
    input logic             rsp_valid,
    input logic [1:0]       fault_kind,
    input logic [15:0]      fault_code,
    input logic [2:0]       stack_idx,
    input logic             inner_priv,
    input logic             clear_if
);
    localparam int CW = VEC_W + LIM_W + 4;

    p_resp_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_no_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_ok_code_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind == 2'd0) |-> (fault_code == 16'h0));

    p_limit_legacy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !long_mode && (CW'({vector, 3'b111}) > CW'(tbl_limit)))
        |=> (fault_kind == 2'd1 && fault_code == 16'({$past(vector), 3'b010})));

    p_legacy_ist_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !long_mode) |=> (stack_idx == 3'd0));

    p_flags_need_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_priv || clear_if) |-> (fault_kind == 2'd0));
endmodule

bind idt_gate_checker igc_checker #(.VEC_W(VEC_W), .LIM_W(LIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .vector     (vector),
    .tbl_limit  (tbl_limit),
    .long_mode  (long_mode),
    .rsp_valid  (rsp_valid),
    .fault_kind (fault_kind),
    .fault_code (fault_code),
    .stack_idx  (stack_idx),
    .inner_priv (inner_priv),
    .clear_if   (clear_if)
);

// File: tb/sim_idt_gate_checker.sv
module sim_idt_gate_checker;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  vector = '0;
    logic [15:0] tbl_limit = '0;
    logic        sw_int = 1'b0;
    logic [1:0]  cpl = '0;
    logic        long_mode = 1'b0;
    logic [63:0] gate_lo = '0;
    logic [63:0] gate_hi = '0;
    logic        tgt_is_code = 1'b0;
    logic [1:0]  tgt_dpl = '0;
    logic        tgt_present = 1'b0;
    logic        tgt_conforming = 1'b0;
    logic        rsp_valid;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;
    logic [3:0]  gate_type;
    logic [15:0] tgt_sel;
    logic [63:0] tgt_offset;
    logic [2:0]  stack_idx;
    logic        inner_priv;
    logic        clear_if;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idt_gate_checker u0 (.*);

    // gate low word: offset low 16 = 0x1000, offset mid = 0
    function automatic logic [63:0] mk(input logic [15:0] sel, input logic [3:0] typ,
                                       input logic s, input logic [1:0] dpl,
                                       input logic p, input logic [2:0] ist);
        return {16'h0000, p, dpl, s, typ, 3'b000, 2'b00, ist, sel, 16'h1000};
    endfunction

    typedef struct packed {
        logic        lm;
        logic        sw;
        logic [1:0]  cpl;
        logic [7:0]  vec;
        logic [15:0] lim;
        logic [63:0] lo;
        logic [63:0] hi;
        logic        tcode;
        logic [1:0]  tdpl;
        logic        tpres;
        logic        tconf;
        logic [1:0]  ekind;
        logic [15:0] ecode;
        logic        einner;
        logic        eclr;
    } tv_t;

    localparam logic [63:0] H0  = 64'h0;
    localparam logic [63:0] HRV = 64'h0000_0400_0000_0000;

    localparam tv_t TV [NVEC] = '{
        '{1'b0,1'b0,2'd0,8'h21,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b0,1'b1},
        '{1'b0,1'b0,2'd3,8'h21,16'h07FF,mk(16'h0008,4'd15,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b1,1'b0},
        '{1'b0,1'b0,2'd3,8'h21,16'h07FF,mk(16'h0008,4'd15,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b1,2'd0,16'h0000,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h10,16'h0087,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b0,1'b1},
        '{1'b0,1'b0,2'd0,8'h11,16'h0087,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h008A,1'b0,1'b0},
        '{1'b1,1'b0,2'd0,8'h10,16'h010F,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b0,1'b1},
        '{1'b1,1'b0,2'd0,8'h10,16'h010E,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0082,1'b0,1'b0},
        '{1'b1,1'b0,2'd0,8'h22,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),HRV,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0112,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h30,16'h07FF,mk(16'h0008,4'd6,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b0,1'b1},
        '{1'b0,1'b0,2'd0,8'h30,16'h07FF,mk(16'h0008,4'd12,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0182,1'b0,1'b0},
        '{1'b1,1'b0,2'd0,8'h30,16'h07FF,mk(16'h0008,4'd6,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0182,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h30,16'h07FF,mk(16'h0008,4'd14,1'b1,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0182,1'b0,1'b0},
        '{1'b0,1'b1,2'd3,8'h80,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0402,1'b0,1'b0},
        '{1'b0,1'b0,2'd3,8'h80,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b1,1'b1},
        '{1'b0,1'b1,2'd3,8'h80,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd3,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd0,16'h0000,1'b1,1'b1},
        '{1'b0,1'b0,2'd0,8'h40,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b0,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd2,16'h0202,1'b0,1'b0},
        '{1'b0,1'b1,2'd3,8'h40,16'h07FF,mk(16'h0008,4'd14,1'b0,2'd0,1'b0,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0202,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h41,16'h07FF,mk(16'h0003,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0000,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h41,16'h07FF,mk(16'h0003,4'd14,1'b0,2'd0,1'b0,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd2,16'h020A,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h21,16'h07FF,mk(16'h001B,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b0,2'd0,1'b1,1'b0,2'd1,16'h0018,1'b0,1'b0},
        '{1'b0,1'b0,2'd1,8'h21,16'h07FF,mk(16'h001B,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd2,1'b1,1'b0,2'd1,16'h0018,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h21,16'h07FF,mk(16'h001B,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b0,1'b0,2'd2,16'h0018,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h21,16'h07FF,mk(16'h001B,4'd14,1'b0,2'd0,1'b1,3'd0),H0,1'b0,2'd0,1'b0,1'b0,2'd1,16'h0018,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h11,16'h0087,mk(16'h0008,4'd12,1'b0,2'd0,1'b0,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h008A,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h50,16'h07FF,mk(16'h0000,4'd5,1'b0,2'd0,1'b1,3'd0),H0,1'b0,2'd0,1'b0,1'b0,2'd0,16'h0000,1'b0,1'b0},
        '{1'b1,1'b0,2'd0,8'h50,16'h07FF,mk(16'h0008,4'd5,1'b0,2'd0,1'b1,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd1,16'h0282,1'b0,1'b0},
        '{1'b0,1'b0,2'd0,8'h50,16'h07FF,mk(16'h0000,4'd5,1'b0,2'd0,1'b0,3'd0),H0,1'b1,2'd0,1'b1,1'b0,2'd2,16'h0282,1'b0,1'b0}
    };

    localparam string TAG [NVEC] = '{
        "R11 int gate", "R11 inner trap", "R11 conforming",
        "R2 limit edge", "R2 limit over", "R2 long edge", "R2 long over",
        "R3 reserved bits", "R4 legacy type6", "R4 type12", "R4 long type6", "R4 segment flag",
        "R5 sw dpl low", "R5 hw ignores dpl", "R5 sw dpl ok",
        "R6 not present", "R9 priv before present", "R7 null selector", "R9 present before selector",
        "R8 not code", "R8 target dpl", "R8 target absent", "R9 kind before present",
        "R9 limit first", "R12 task gate", "R4 long task", "R12 task absent"
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input tv_t t);
        @(negedge clk);
        req_valid = 1'b1;
        long_mode = t.lm; sw_int = t.sw; cpl = t.cpl; vector = t.vec; tbl_limit = t.lim;
        gate_lo = t.lo; gate_hi = t.hi;
        tgt_is_code = t.tcode; tgt_dpl = t.tdpl; tgt_present = t.tpres; tgt_conforming = t.tconf;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        tv_t t;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 reset kind", 64'(fault_kind), 64'd0);
        check("R1 reset offset", tgt_offset, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(TV[i]);
            check({TAG[i], " valid"}, 64'(rsp_valid), 64'd1);
            check({TAG[i], " kind"},  64'(fault_kind), 64'(TV[i].ekind));
            check({TAG[i], " code"},  64'(fault_code), 64'(TV[i].ecode));
            check({TAG[i], " inner"}, 64'(inner_priv), 64'(TV[i].einner));
            check({TAG[i], " clrif"}, 64'(clear_if), 64'(TV[i].eclr));
        end

        // R10: long-mode offset and stack index
        t = TV[0];
        t.lm = 1'b1;
        t.lo = {16'h89AB, 1'b1, 2'd0, 1'b0, 4'd14, 3'b000, 5'b00101, 16'h0008, 16'hCDEF};
        t.hi = 64'h0000_0000_0123_4567;
        drive(t);
        check("R10 long offset", tgt_offset, 64'h0123_4567_89AB_CDEF);
        check("R10 long ist", 64'(stack_idx), 64'd5);
        check("R10 selector", 64'(tgt_sel), 64'h0008);
        check("R10 type", 64'(gate_type), 64'd14);
        // R1: outputs hold and valid drops without a request
        @(negedge clk);
        check("R1 valid drops", 64'(rsp_valid), 64'd0);
        check("R1 offset holds", tgt_offset, 64'h0123_4567_89AB_CDEF);
        // R10: legacy ignores the high word and the parameter field
        t.lm = 1'b0;
        drive(t);
        check("R10 legacy offset", tgt_offset, 64'h0000_0000_89AB_CDEF);
        check("R10 legacy ist", 64'(stack_idx), 64'd0);
        check("R10 legacy kind", 64'(fault_kind), 64'd0);
        // R12: task gate reports its selector
        t = TV[24];
        t.lo = mk(16'h0030, 4'd5, 1'b0, 2'd0, 1'b1, 3'd0);
        drive(t);
        check("R12 task selector", 64'(tgt_sel), 64'h0030);
        check("R12 task kind", 64'(fault_kind), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule